// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobes

This block presents a five-digit BCD result on a single shared 4-bit bus, one digit at a time. It drives five one-hot digit enables in turn, from the most significant digit to the least, so that a multiplexed display or a downstream capture circuit can tell which digit is on the bus. The result is captured from `digitsIn` only when a measurement-end pulse arrives, so a scan never shows a mix of old and new digits.

The block's clock runs at twice the count rate, and one count is two clock cycles. This lets each capture strobe be exactly half a count wide. After every new measurement the block emits one burst of five active-low strobes. Each strobe sits in the middle of its digit slot, where the bus and the enables are settled, and a latch or a processor can take the digit then. When the captured measurement carried an overrange flag, all enables and the bus are forced low once the burst has finished. They stay low until a reference-integrate-start pulse, and then scanning restarts at the top digit. This makes the display blink.

All outputs are registered.

Top module: `bcd_digit_scanner`

## Requirements
- R1: `digitEn` is one-hot or all zero. Bit 4 enables the most significant digit and bit 0 the least significant. The scan visits bit 4, 3, 2, 1, 0 in that order and then wraps back to bit 4 without stopping.
- R2: One count is two clock cycles. Every digit slot lasts 200 counts (400 clocks), except the slot named in R3.
- R3: Take the clock edge that samples `measEnd` high as edge 0. Scanning restarts at bit 4 at edge 1, and this first slot lasts 201 counts (402 clocks).
- R4: While a digit is enabled, `bcdOut` carries that digit of the captured result, active high. `digitsIn[19:16]` is the digit of bit 4 and `digitsIn[3:0]` is the digit of bit 0. The bus changes on the same edge as the enables.
- R5: Each `measEnd` is followed by exactly five `strobeN` low pulses, each one clock wide. The first pulse is at count 101 of the first slot, so it is low after edge 204. Each later pulse is at count 100 of its slot, low after edges 604, 1004, 1404 and 1804.
- R6: No strobe occurs after reset or after a burst until the next `measEnd`, even though scanning goes on.
- R7: The captured result changes only on `measEnd`. A change on `digitsIn` at any other time has no effect on `bcdOut`.
- R8: If `overrange` was high when `measEnd` was sampled, `digitEn` and `bcdOut` are all zero from edge 1805 onward. They stay zero until `refStart` is sampled high at some edge R. At edge R+1 scanning restarts at bit 4, and that slot lasts 200 counts.
- R9: `refStart` has no effect unless the display is blanked by R8.
- R10: While `rstN` is low, `digitEn` and `bcdOut` are zero and `strobeN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the count rate |
| rstN | input | 1 | Active-low synchronous reset |
| measEnd | input | 1 | One-clock pulse: new result ready, capture digits |
| refStart | input | 1 | One-clock pulse: reference integrate begins |
| overrange | input | 1 | Overrange flag, sampled with measEnd |
| digitsIn | input | 20 | Five BCD digits, most significant in the top nibble |
| digitEn | output | 5 | One-hot digit enables, bit 4 is the most significant digit |
| bcdOut | output | 4 | BCD value of the enabled digit |
| strobeN | output | 1 | Active-low capture strobe |

## Verification
The bench checks every clock of whole scans against enable and strobe patterns that it computes itself. A design that gave the first slot 200 counts instead of 201 would put every strobe and every later digit change one count early. A design whose strobe counter did not stop would show a sixth strobe in the following digit slot.

The bench changes `digitsIn` in the middle of a scan with no `measEnd`. A design that did not hold the captured result would then show the new digits on the bus.

The bench also pulses `refStart` while the display is not blanked, and again while it is blanked after an overrange. A design that obeyed the first pulse would restart its scan and shift every later slot. A design that ignored the second pulse would stay dark, and one that blanked too early would swallow the last digit or its strobe.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // controls sent from the scan controller to the output datapath
  typedef struct packed {
    logic load;    // capture new result
    logic blank;   // force enables and bus low
    logic strobe;  // strobe active in this clock
  } scanCtl_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int SLOT = 200,
  parameter int NDIG = 5,
  localparam int PW  = $clog2(SLOT + 2),
  localparam int IW  = $clog2(NDIG),
  localparam int SW  = $clog2(NDIG + 1),
  localparam int MID = SLOT / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          measEnd,
  input  logic          refStart,
  input  logic          overrange,
  output scanCtl_t      ctl,
  output logic [IW-1:0] idx
);
  logic          phase;
  logic [PW-1:0] pos;
  logic          longSlot;
  logic [SW-1:0] strobesLeft;
  logic          orHeld;
  logic          blank;
  logic [PW-1:0] lastPos;
  logic [PW-1:0] midPos;
  logic          strobeNow;

  always_comb begin
    lastPos   = longSlot ? PW'(SLOT) : PW'(SLOT - 1);
    midPos    = PW'(MID) + PW'(longSlot);
    strobeNow = (strobesLeft != '0) && phase && (pos == midPos);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= 1'b0;
      pos         <= '0;
      idx         <= '0;
      longSlot    <= 1'b0;
      strobesLeft <= '0;
      orHeld      <= 1'b0;
      blank       <= 1'b0;
    end else if (measEnd) begin
      phase       <= 1'b0;
      pos         <= '0;
      idx         <= '0;
      longSlot    <= 1'b1;
      strobesLeft <= SW'(NDIG);
      orHeld      <= overrange;
      blank       <= 1'b0;
    end else if (blank && refStart) begin
      phase    <= 1'b0;
      pos      <= '0;
      idx      <= '0;
      longSlot <= 1'b0;
      orHeld   <= 1'b0;
      blank    <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (pos == lastPos) begin
          pos      <= '0;
          longSlot <= 1'b0;
          idx      <= (idx == IW'(NDIG - 1)) ? '0 : idx + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
      if (strobeNow) begin
        strobesLeft <= strobesLeft - 1'b1;
        if (strobesLeft == SW'(1) && orHeld) blank <= 1'b1;
      end
    end
  end

  assign ctl.load   = measEnd;
  assign ctl.blank  = blank;
  assign ctl.strobe = strobeNow;

  // R2: the digit index moves only at a slot end or on a restart
  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!measEnd && !(blank && refStart) && !(phase && pos == lastPos)) |=> $stable(idx));
endmodule

// File: rtl/scan_data.sv
module scan_data
  import scan_pkg::*;
#(
  parameter int NDIG = 5,
  parameter int DW   = 4,
  localparam int IW  = $clog2(NDIG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NDIG*DW-1:0] digitsIn,
  input  scanCtl_t           ctl,
  input  logic [IW-1:0]      idx,
  output logic [NDIG-1:0]    digitEn,
  output logic [DW-1:0]      bcdOut,
  output logic               strobeN
);
  logic [NDIG*DW-1:0] resultQ;
  logic [DW-1:0]      dig [NDIG];
  logic [IW-1:0]      selIdx;
  logic [NDIG-1:0]    enNext;
  logic [DW-1:0]      bcdNext;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign dig[g] = resultQ[g*DW +: DW];
  end

  always_comb begin
    selIdx  = IW'(NDIG - 1) - idx;
    enNext  = ctl.blank ? '0 : (NDIG'(1) << selIdx);
    bcdNext = ctl.blank ? '0 : dig[selIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      digitEn <= '0;
      bcdOut  <= '0;
      strobeN <= 1'b1;
    end else begin
      if (ctl.load) resultQ <= digitsIn;
      digitEn <= enNext;
      bcdOut  <= bcdNext;
      strobeN <= ~ctl.strobe;
    end
  end

  // R1: at most one digit enabled
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(digitEn));
  // R5: a strobe is one clock wide
  a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rstN) !strobeN |=> strobeN);
  // R8: blanking forces the outputs low
  a_r8_blank_out: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blank |=> (digitEn == '0 && bcdOut == '0));
  // R7: result held between measurement ends
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN) !ctl.load |=> $stable(resultQ));
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import scan_pkg::*;
#(
  parameter int SLOT = 200,
  parameter int NDIG = 5,
  parameter int DW   = 4,
  localparam int IW  = $clog2(NDIG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               measEnd,
  input  logic               refStart,
  input  logic               overrange,
  input  logic [NDIG*DW-1:0] digitsIn,
  output logic [NDIG-1:0]    digitEn,
  output logic [DW-1:0]      bcdOut,
  output logic               strobeN
);
  scanCtl_t      ctl;
  logic [IW-1:0] idx;

  scan_ctrl #(.SLOT(SLOT), .NDIG(NDIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .measEnd(measEnd), .refStart(refStart),
    .overrange(overrange), .ctl(ctl), .idx(idx)
  );

  scan_data #(.NDIG(NDIG), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .digitsIn(digitsIn), .ctl(ctl), .idx(idx),
    .digitEn(digitEn), .bcdOut(bcdOut), .strobeN(strobeN)
  );
endmodule

// File: tb/sim_bcd_digit_scanner.sv
`timescale 1ns/1ps
module sim_bcd_digit_scanner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        measEnd = 1'b0;
  logic        refStart = 1'b0;
  logic        overrange = 1'b0;
  logic [19:0] digitsIn = '0;
  logic [4:0]  digitEn;
  logic [3:0]  bcdOut;
  logic        strobeN;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_digit_scanner u0 (
    .clk(clk), .rstN(rstN), .measEnd(measEnd), .refStart(refStart),
    .overrange(overrange), .digitsIn(digitsIn), .digitEn(digitEn),
    .bcdOut(bcdOut), .strobeN(strobeN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int digitAt(input int c, input bit firstLong);
    int slot;
    if (firstLong) slot = (c < 201) ? 0 : 1 + (c - 201) / 200;
    else slot = c / 200;
    return slot % 5;
  endfunction

  function automatic int expBcd(input logic [19:0] d, input int dg);
    return int'((d >> (4 * (4 - dg))) & 20'hF);
  endfunction

  task automatic pulseMeas(input logic [19:0] d, input bit ovr);
    @(negedge clk);
    digitsIn = d; overrange = ovr; measEnd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    measEnd = 1'b0; overrange = 1'b0;
  endtask

  // R10 reset state, then R6 no strobes before any measurement
  task automatic tReset();
    int strobes = 0;
    int badEn = 0;
    repeat (3) @(negedge clk);
    chk("R10 digitEn in reset", int'(digitEn), 0);
    chk("R10 bcdOut in reset", int'(bcdOut), 0);
    chk("R10 strobeN in reset", int'(strobeN), 1);
    rstN = 1'b1;
    for (int n = 1; n <= 1200; n++) begin
      @(posedge clk); @(negedge clk);
      if (!strobeN) strobes++;
      if ($countones(digitEn) != 1) badEn++;
    end
    chk("R6 strobes after reset", strobes, 0);
    chk("R1 one enable after reset", badEn, 0);
  endtask

  // R1 R2 R3 R4 R5 with optional R9 refStart pulse at sample refAt
  task automatic tNormal(input logic [19:0] d, input int refAt);
    int badEn = 0, badBcd = 0, strobes = 0, badStr = 0;
    pulseMeas(d, 1'b0);
    for (int n = 1; n <= 2800; n++) begin
      int dg;
      bit expLow;
      @(posedge clk); @(negedge clk);
      refStart = (n == refAt);
      dg = digitAt((n - 1) / 2, 1'b1);
      if (digitEn != (5'b10000 >> dg)) begin
        if (badEn == 0) $display("  first enable mismatch at %0d: %b", n, digitEn);
        badEn++;
      end
      if (int'(bcdOut) != expBcd(d, dg)) badBcd++;
      expLow = (n >= 204) && (n <= 1804) && ((n - 204) % 400 == 0);
      if (!strobeN) strobes++;
      if (strobeN == expLow) badStr++;
    end
    refStart = 1'b0;
    chk(refAt > 0 ? "R9 enable sequence with stray refStart" : "R3 R2 R1 enable sequence", badEn, 0);
    chk("R4 bus value per digit", badBcd, 0);
    chk("R5 strobe positions", badStr, 0);
    chk("R5 strobe count", strobes, 5);
  endtask

  // R7 changed inputs without measEnd are ignored, R6 no further strobes
  task automatic tHold(input logic [19:0] d, input logic [19:0] other);
    int badBcd = 0, strobes = 0;
    @(negedge clk);
    digitsIn = other;
    for (int n = 0; n < 2400; n++) begin
      int dg;
      @(posedge clk); @(negedge clk);
      dg = 0;
      for (int k = 0; k < 5; k++) if (digitEn[4 - k]) dg = k;
      if (int'(bcdOut) != expBcd(d, dg)) badBcd++;
      if (!strobeN) strobes++;
    end
    chk("R7 result held without measEnd", badBcd, 0);
    chk("R6 no strobes after burst", strobes, 0);
  endtask

  // R8 overrange blanking and restart on refStart
  task automatic tOver(input logic [19:0] d);
    int badEn = 0, badBlank = 0, strobes = 0, badRe = 0, strobes2 = 0;
    pulseMeas(d, 1'b1);
    for (int n = 1; n <= 2400; n++) begin
      @(posedge clk); @(negedge clk);
      if (!strobeN) strobes++;
      if (n <= 1804) begin
        if (digitEn != (5'b10000 >> digitAt((n - 1) / 2, 1'b1))) badEn++;
      end else if (digitEn != 0 || bcdOut != 0) badBlank++;
    end
    chk("R8 scan before blanking", badEn, 0);
    chk("R8 blank after burst", badBlank, 0);
    chk("R5 strobe count with overrange", strobes, 5);
    refStart = 1'b1;
    @(posedge clk); @(negedge clk);
    refStart = 1'b0;
    for (int m = 1; m <= 2000; m++) begin
      @(posedge clk); @(negedge clk);
      if (!strobeN) strobes2++;
      if (digitEn != (5'b10000 >> digitAt((m - 1) / 2, 1'b0))) begin
        if (badRe == 0) $display("  first restart mismatch at %0d: %b", m, digitEn);
        badRe++;
      end
    end
    chk("R8 restart at top digit after refStart", badRe, 0);
    chk("R6 no strobes after restart", strobes2, 0);
  endtask

  initial begin
    tReset();
    tNormal(20'h1_2345, 0);
    tHold(20'h1_2345, 20'h9_8765);
    tNormal(20'h0_9807, 300);
    tOver(20'h1_9999);
    tNormal(20'h0_4321, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule